// File: doc/BRIEF.md
# Sub-Word Load/Store Memory Port

A small data memory organised as rows of eight bytes, reached through a byte-addressed request port. The low three address bits pick a byte lane inside a row, and the bits above them select the row. An access moves 1, 2, 4 or 8 bytes. A narrow load lifts the addressed lanes out of the row and returns them right-justified and zero-extended. A narrow store reads the row, replaces only the addressed lanes with the new bytes, and writes the merged row back in the same cycle.

Each access can ask for its bytes to be reversed within the access width. A load reverses after extraction, and a store reverses before merging. A request whose byte offset is not a multiple of its width is refused: it is flagged as an error and leaves the storage untouched. Every request gets exactly one response, one clock cycle later.

Top module: `subword_mem_port`

## Requirements
- R1: After reset the response outputs are low (rsp_valid=0, rsp_err=0, rsp_rdata=0), and every row reads as zero until it is written.
- R2: rsp_valid is high in the cycle after each cycle in which req was high, and low after a cycle without req.
- R3: size encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A load returns the bytes at row offsets addr[2:0] up to addr[2:0]+width-1, with the byte at the lowest offset in rsp_rdata[7:0] and all bits above the width zero.
- R4: A store narrower than 8 bytes changes only the addressed bytes of the row. The other bytes keep their values.
- R5: An 8-byte store at offset 0 replaces the whole row with wdata.
- R6: A load with swap=1 returns the extracted value with its bytes reversed within the access width.
- R7: A store with swap=1 writes the low width bytes of wdata in reversed order: byte k of the stored value is wdata byte width-1-k. wdata bits above the width are ignored whether or not swap is set.
- R8: A request with addr[2:0] not a multiple of the width gives rsp_err=1 with rsp_valid=1 and rsp_rdata=0, and leaves every row unchanged.
- R9: The row index is addr[3 +: log2(ROWS)]. Address bits above it have no effect.
- R10: A legal store responds with rsp_err=0 and rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 64 | Byte address |
| size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| swap | input | 1 | Reverse the bytes of the access value |
| wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 64 | Load result, zero-extended |
| rsp_err | output | 1 | Misaligned request refused |

## Verification
All three response outputs are registered once. Their values for a request presented before a rising edge appear right after that edge. The bench drives each request on a falling edge and reads the response on the next falling edge, one full cycle later, so that it sees exactly that request's response. A store's merge happens at the same edge as its response, so a load issued in the following cycle must already see the new bytes. The bench's byte-level model is updated at the moment the store response is checked, which keeps the two in step.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int unsigned ROW_BYTES = 8;
  localparam int unsigned ROW_BITS  = ROW_BYTES * 8;
  localparam int unsigned OFS_W     = $clog2(ROW_BYTES);

  typedef logic [ROW_BITS-1:0] row_t;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/smp_lane_align.sv
module smp_lane_align
  import smp_pkg::*;
(
  input  logic [OFS_W-1:0] offset,
  input  acc_size_e        size,
  output logic [5:0]       lane_shift,
  output row_t             width_mask,
  output logic             misalign
);
  logic [OFS_W:0] bytes_m1;

  always_comb begin
    bytes_m1   = (OFS_W'(1) << size) - 1'b1;
    misalign   = |(offset & bytes_m1[OFS_W-1:0]);
    lane_shift = {offset, 3'b000};
    if (size == SZ_B8) begin
      width_mask = '1;
    end else begin
      width_mask = (row_t'(1) << (7'd8 << size)) - row_t'(1);
    end
  end
endmodule

// File: rtl/smp_byte_swap.sv
module smp_byte_swap
  import smp_pkg::*;
(
  input  row_t      din,
  input  acc_size_e size,
  input  logic      enable,
  output row_t      dout
);
  always_comb begin
    int nbytes;
    nbytes = 1 << size;
    dout   = '0;
    for (int i = 0; i < ROW_BYTES; i++) begin
      if (i < nbytes) begin
        if (enable) dout[i*8 +: 8] = din[(nbytes-1-i)*8 +: 8];
        else        dout[i*8 +: 8] = din[i*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/smp_row_store.sv
module smp_row_store
  import smp_pkg::*;
#(
  parameter int unsigned ROWS  = 256,
  localparam int unsigned IDX_W = $clog2(ROWS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output row_t             rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  row_t             wr_data
);
  row_t mem_q [ROWS];
  row_t mem_d [ROWS];

  assign rd_data = mem_q[rd_idx];

  always_comb begin
    mem_d = mem_q;
    if (wr_en) mem_d[wr_idx] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  // R5
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/subword_mem_port.sv
module subword_mem_port
  import smp_pkg::*;
#(
  parameter int unsigned ROWS   = 256,
  localparam int unsigned IDX_W = $clog2(ROWS)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [63:0] addr,
  input  logic [1:0]  size,
  input  logic        swap,
  input  logic [63:0] wdata,
  output logic        rsp_valid,
  output logic [63:0] rsp_rdata,
  output logic        rsp_err
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  acc_size_e        acc_size;
  logic [OFS_W-1:0] offset;
  logic [IDX_W-1:0] row_idx;
  logic [5:0]       lane_shift;
  row_t             width_mask;
  logic             misalign;
  row_t             row_rd;
  row_t             ld_raw, ld_val;
  row_t             st_raw, st_val, merged;
  logic             wr_en;

  assign acc_size = acc_size_e'(size);
  assign offset   = addr[OFS_W-1:0];
  assign row_idx  = addr[OFS_W +: IDX_W];

  smp_lane_align u_align (
    .offset     (offset),
    .size       (acc_size),
    .lane_shift (lane_shift),
    .width_mask (width_mask),
    .misalign   (misalign)
  );

  smp_row_store #(.ROWS(ROWS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rd_idx  (row_idx),
    .rd_data (row_rd),
    .wr_en   (wr_en),
    .wr_idx  (row_idx),
    .wr_data (merged)
  );

  // load path: extract then optionally reverse
  assign ld_raw = (row_rd >> lane_shift) & width_mask;

  smp_byte_swap u_ld_swap (
    .din    (ld_raw),
    .size   (acc_size),
    .enable (swap),
    .dout   (ld_val)
  );

  // store path: trim, optionally reverse, then merge
  assign st_raw = wdata & width_mask;

  smp_byte_swap u_st_swap (
    .din    (st_raw),
    .size   (acc_size),
    .enable (swap),
    .dout   (st_val)
  );

  assign merged = (row_rd & ~(width_mask << lane_shift)) | (st_val << lane_shift);
  assign wr_en  = req & we & ~misalign;

  // response next state
  logic valid_d, err_d;
  row_t rdata_d;

  always_comb begin
    valid_d = req;
    err_d   = req & misalign;
    rdata_d = '0;
    if (req && !we && !misalign) rdata_d = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_err   <= err_d;
      rsp_rdata <= rdata_d;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    req |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !req |=> !rsp_valid);
  // R8
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  // R10
  store_rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req && we) |=> rsp_rdata == '0);
  // R3
  narrow_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req && !we && acc_size == SZ_B1) |=> rsp_rdata[63:8] == '0);
endmodule

// File: tb/tb_subword_mem_port.sv
`timescale 1ns/1ps
module tb_subword_mem_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we, swap;
  logic [63:0] addr, wdata;
  logic [1:0]  size;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  byte unsigned model [256*8];

  always #4 clk = ~clk;

  subword_mem_port dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .size(size), .swap(swap), .wdata(wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int base_of(logic [63:0] a);
    return int'(a[10:3]) * 8 + int'(a[2:0]);
  endfunction

  function automatic bit is_mis(logic [63:0] a, logic [1:0] s);
    int n = 1 << s;
    return (int'(a[2:0]) % n) != 0;
  endfunction

  function automatic logic [63:0] exp_load(logic [63:0] a, logic [1:0] s, logic sw);
    logic [63:0] v = '0;
    int n = 1 << s;
    int b = base_of(a);
    for (int k = 0; k < n; k++)
      v[k*8 +: 8] = sw ? model[b+n-1-k] : model[b+k];
    return v;
  endfunction

  task automatic model_store(logic [63:0] a, logic [1:0] s, logic sw, logic [63:0] d);
    int n = 1 << s;
    int b = base_of(a);
    for (int k = 0; k < n; k++)
      model[b+k] = sw ? d[(n-1-k)*8 +: 8] : d[k*8 +: 8];
  endtask

  // one request, response read one cycle later on the falling edge
  task automatic access(string tag, logic w, logic [63:0] a, logic [1:0] s,
                        logic sw, logic [63:0] d);
    logic mis;
    logic [63:0] exp;
    mis = is_mis(a, s);
    exp = (w || mis) ? 64'd0 : exp_load(a, s, sw);
    @(negedge clk);
    req = 1; we = w; addr = a; size = s; swap = sw; wdata = d;
    @(negedge clk);
    req = 0;
    check({tag, " valid"}, {63'd0, rsp_valid}, 64'd1);
    check({tag, " err"}, {63'd0, rsp_err}, {63'd0, mis});
    check({tag, " rdata"}, rsp_rdata, exp);
    if (w && !mis) model_store(a, s, sw, d);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (model[i]) model[i] = 8'h00;
    req = 0; we = 0; swap = 0; addr = '0; size = '0; wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 err",   {63'd0, rsp_err}, 64'd0);
    check("R1 rdata", rsp_rdata, 64'd0);
    access("R1 unwritten row", 0, 64'h28, 2'd3, 0, '0);
    access("R1 unwritten high row", 64'h7F8, 2'd2, 0, 0, '0);
    // R5 full row
    access("R5 full store", 1, 64'h28, 2'd3, 0, 64'h8877665544332211);
    access("R5 full load", 0, 64'h28, 2'd3, 0, '0);
    // R3 narrow loads
    for (int o = 0; o < 8; o++) access("R3 byte load", 0, 64'h28 + o, 2'd0, 0, '0);
    access("R3 half load", 0, 64'h2A, 2'd1, 0, '0);
    access("R3 word load", 0, 64'h2C, 2'd2, 0, '0);
    // R6 swapped loads
    access("R6 swap word", 0, 64'h2C, 2'd2, 1, '0);
    access("R6 swap full", 0, 64'h28, 2'd3, 1, '0);
    // R4 narrow store keeps neighbours, R10 store response
    access("R4 R10 half store", 1, 64'h2A, 2'd1, 0, 64'hFFFF_FFFF_FFFF_ABCD);
    access("R4 reload", 0, 64'h28, 2'd3, 0, '0);
    // R7 swapped store, upper wdata ignored
    access("R7 swap store", 1, 64'h2C, 2'd2, 1, 64'hDEAD_BEEF_0A0B_0C0D);
    access("R7 reload", 0, 64'h28, 2'd3, 0, '0);
    // R8 misaligned store changes nothing
    access("R8 mis store", 1, 64'h29, 2'd1, 0, 64'h1234);
    access("R8 mis load", 0, 64'h2E, 2'd2, 0, '0);
    access("R8 reload", 0, 64'h28, 2'd3, 0, '0);
    // R9 high address bits alias
    access("R9 alias load", 0, 64'hF000_0000_0000_0828, 2'd3, 0, '0);
    access("R9 alias store", 1, 64'h8000_0000_0001_0029, 2'd0, 0, 64'h5A);
    access("R9 reload", 0, 64'h28, 2'd3, 0, '0);
    // R2 idle cycle
    @(negedge clk);
    check("R2 idle valid", {63'd0, rsp_valid}, 64'd0);
    // random mix
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      a[10:3] = 8'($urandom_range(0, 15));
      access("R3 R4 R6 R7 R8 random", 1'($urandom), a, 2'($urandom),
             1'($urandom), {$urandom, $urandom});
      if (($urandom & 7) == 0) begin
        @(negedge clk);
        check("R2 random idle", {63'd0, rsp_valid}, 64'd0);
      end
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule